// File: doc/BRIEF.md
# Event-Driven Single-Datum Transfer Engine

The block serves eight request lines. Each line belongs to a channel, and each channel holds a control word, a source pointer and a destination pointer. When a channel's request is granted, the engine reads one byte or one 16-bit word from the source pointer and writes it to the destination pointer. All addresses lie in a 64 KB data segment. After the write, the engine can advance either the source pointer or the destination pointer by the size of the datum, and it counts the channel's transfer counter down by one.

When a channel is granted while its counter is already zero, the engine moves no data. It raises a one-cycle interrupt flag for that channel instead, so the host can service the channel by the normal path.

Software programs the channels through a simple write port with a registered read-back. The engine drives a plain 16-bit memory bus with byte enables. A read strobe returns data one clock later. A write strobe completes in its own cycle.

Top module: `evx_dma`

## Requirements
- R1: After reset every control word and pointer reads 0, and mem_re_o, mem_we_o, done_o and irq_o are all low.
- R2: The control word is laid out as count in bits [7:0], size select in bit 8 (0 = word, 1 = byte) and step mode in bits [10:9]. Bits [15:11] read as 0. A write of step mode 11 is stored and read back as 10.
- R3: A word transfer reads at the source pointer with bit 0 cleared and writes the same 16-bit value at the destination pointer with bit 0 cleared. Both byte enables (mem_be_o = 11) are set on both cycles.
- R4: A byte transfer takes the source byte from lane 0 (even address, be 01) or lane 1 (odd address, be 10). It writes that byte on the destination's lane with only that byte enable set, and the other destination byte is left unchanged.
- R5: Step mode 00 leaves both pointers unchanged, 01 advances the destination pointer and 10 advances the source pointer. The step is 1 for a byte and 2 for a word.
- R6: Each completed transfer lowers the channel's count by exactly one.
- R7: A grant with count zero issues no bus cycle, asserts bit ch of irq_o for one cycle, and leaves the count and pointers unchanged.
- R8: Pending requests are served lowest channel number first, one transfer per grant. A request that arrives while another transfer is running is held until it is served.
- R9: done_o bit ch pulses for one cycle, in the cycle after the write cycle. At most one bit of done_o is high at a time.
- R10: The write cycle of a transfer comes exactly two cycles after its read cycle, and a read and a write are never issued in the same cycle.
- R11: The register map uses byte addresses. Control word ch is at 2*ch, source pointer ch at 0x10+2*ch and destination pointer ch at 0x20+2*ch. Address bit 0 is ignored, and reads of 0x30 to 0x3F return 0. Read data appears one cycle after the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 8 | Per-channel service request pulses |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register byte address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Registered read data for reg_addr_i |
| mem_re_o | output | 1 | Memory read strobe |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | 16 | Memory byte address |
| mem_be_o | output | 2 | Byte enables (bit 0 = low lane) |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rdata_i | input | 16 | Memory read data, valid one cycle after mem_re_o |
| done_o | output | 8 | One-cycle transfer-complete pulse per channel |
| irq_o | output | 8 | One-cycle count-exhausted flag per channel |

## Verification
The bench builds the block with its defaults: eight channels and an 8-bit count. With these values the full register map is reachable, as are the count-zero path and random counts up to 255. Priority is tested among channels that are far apart in number. Pointers are kept within the first kilobyte so that a small memory model covers them. Even and odd source and destination addresses are mixed, which reaches all four byte-lane pairings as well as the case where a word transfer clears bit 0 of an address.

// File: rtl/evx_pkg.sv
package evx_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RD   = 2'd1,
    S_WAIT = 2'd2,
    S_WR   = 2'd3
  } evx_state_e;

  localparam logic [1:0] STEP_NONE = 2'b00;
  localparam logic [1:0] STEP_DST  = 2'b01;
  localparam logic [1:0] STEP_SRC  = 2'b10;
  localparam logic [1:0] STEP_BAD  = 2'b11;

  localparam logic [1:0] GRP_CTL = 2'd0;
  localparam logic [1:0] GRP_SRC = 2'd1;
  localparam logic [1:0] GRP_DST = 2'd2;
endpackage

// File: rtl/evx_regfile.sv
module evx_regfile import evx_pkg::*; #(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 8,
  parameter int PTR_W  = 16,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int RA_W  = CH_W + 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_we,
  input  logic [RA_W-1:0]  host_addr,
  input  logic [15:0]      host_wdata,
  output logic [15:0]      host_rdata,
  input  logic [CH_W-1:0]  sel_ch,
  output logic [CNT_W-1:0] sel_cnt,
  output logic             sel_byte,
  output logic [1:0]       sel_step,
  output logic [PTR_W-1:0] sel_src,
  output logic [PTR_W-1:0] sel_dst,
  input  logic             upd_en,
  input  logic [CH_W-1:0]  upd_ch,
  input  logic [CNT_W-1:0] upd_cnt,
  input  logic [PTR_W-1:0] upd_src,
  input  logic [PTR_W-1:0] upd_dst
);
  localparam int BYTE_BIT = CNT_W;
  localparam int STEP_LO  = CNT_W + 1;

  logic [CH_W-1:0]  h_idx;
  logic [1:0]       h_grp;
  logic [1:0]       h_step;
  logic [CNT_W-1:0] cnt_a  [NUM_CH];
  logic             byte_a [NUM_CH];
  logic [1:0]       step_a [NUM_CH];
  logic [PTR_W-1:0] src_a  [NUM_CH];
  logic [PTR_W-1:0] dst_a  [NUM_CH];

  assign h_idx  = host_addr[CH_W:1];
  assign h_grp  = host_addr[RA_W-1:CH_W+1];
  assign h_step = (host_wdata[STEP_LO+1:STEP_LO] == STEP_BAD) ? STEP_SRC
                : host_wdata[STEP_LO+1:STEP_LO];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [CNT_W-1:0] cnt_q;
    logic             byte_q;
    logic [1:0]       step_q;
    logic [PTR_W-1:0] src_q;
    logic [PTR_W-1:0] dst_q;
    logic             hit;

    assign hit = host_we && (h_idx == CH_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        cnt_q  <= '0;
        byte_q <= 1'b0;
        step_q <= STEP_NONE;
        src_q  <= '0;
        dst_q  <= '0;
      end else if (upd_en && upd_ch == CH_W'(g)) begin
        cnt_q <= upd_cnt;
        src_q <= upd_src;
        dst_q <= upd_dst;
      end else if (hit) begin
        case (h_grp)
          GRP_CTL: begin
            cnt_q  <= host_wdata[CNT_W-1:0];
            byte_q <= host_wdata[BYTE_BIT];
            step_q <= h_step;
          end
          GRP_SRC: src_q <= host_wdata[PTR_W-1:0];
          GRP_DST: dst_q <= host_wdata[PTR_W-1:0];
          default: ;
        endcase
      end
    end

    assign cnt_a[g]  = cnt_q;
    assign byte_a[g] = byte_q;
    assign step_a[g] = step_q;
    assign src_a[g]  = src_q;
    assign dst_a[g]  = dst_q;
  end

  assign sel_cnt  = cnt_a[sel_ch];
  assign sel_byte = byte_a[sel_ch];
  assign sel_step = step_a[sel_ch];
  assign sel_src  = src_a[sel_ch];
  assign sel_dst  = dst_a[sel_ch];

  logic [15:0] ctl_word;
  always_comb begin
    ctl_word = '0;
    ctl_word[CNT_W-1:0] = cnt_a[h_idx];
    ctl_word[BYTE_BIT]  = byte_a[h_idx];
    ctl_word[STEP_LO+1:STEP_LO] = step_a[h_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
    end else begin
      case (h_grp)
        GRP_CTL: host_rdata <= ctl_word;
        GRP_SRC: host_rdata <= 16'(src_a[h_idx]);
        GRP_DST: host_rdata <= 16'(dst_a[h_idx]);
        default: host_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/evx_arbiter.sv
module evx_arbiter #(
  parameter int NUM_CH = 8,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] req_i,
  input  logic              take_i,
  input  logic [CH_W-1:0]   take_ch_i,
  output logic              any_o,
  output logic [CH_W-1:0]   win_o
);
  logic [NUM_CH-1:0] pend_q;
  logic [NUM_CH-1:0] clr;

  always_comb begin
    clr = '0;
    if (take_i) clr[take_ch_i] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~clr) | req_i;
  end

  always_comb begin
    win_o = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (pend_q[i]) win_o = CH_W'(i);
    end
  end

  assign any_o = |pend_q;
endmodule

// File: rtl/evx_engine.sv
module evx_engine import evx_pkg::*; #(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 8,
  parameter int PTR_W  = 16,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              any_pend,
  input  logic [CH_W-1:0]   win_ch,
  output logic              take,
  output logic [CH_W-1:0]   sel_ch,
  input  logic [CNT_W-1:0]  sel_cnt,
  input  logic              sel_byte,
  input  logic [1:0]        sel_step,
  input  logic [PTR_W-1:0]  sel_src,
  input  logic [PTR_W-1:0]  sel_dst,
  output logic              upd_en,
  output logic [CNT_W-1:0]  upd_cnt,
  output logic [PTR_W-1:0]  upd_src,
  output logic [PTR_W-1:0]  upd_dst,
  output logic              mem_re,
  output logic              mem_we,
  output logic [PTR_W-1:0]  mem_addr,
  output logic [1:0]        mem_be,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata,
  output logic [NUM_CH-1:0] done,
  output logic [NUM_CH-1:0] irq
);
  evx_state_e       state;
  logic [CH_W-1:0]  cur_ch;
  logic             byte_q;
  logic             src_odd;
  logic [PTR_W-1:0] step_amt;
  logic [7:0]       rd_byte;

  function automatic logic [PTR_W-1:0] bus_addr(input logic [PTR_W-1:0] p, input logic b);
    return b ? p : {p[PTR_W-1:1], 1'b0};
  endfunction

  function automatic logic [1:0] lane_en(input logic a0, input logic b);
    return !b ? 2'b11 : (a0 ? 2'b10 : 2'b01);
  endfunction

  assign sel_ch   = (state == S_IDLE) ? win_ch : cur_ch;
  assign take     = (state == S_IDLE) && any_pend;
  assign step_amt = sel_byte ? PTR_W'(1) : PTR_W'(2);
  assign rd_byte  = src_odd ? mem_rdata[15:8] : mem_rdata[7:0];

  assign upd_en  = (state == S_WR);
  assign upd_cnt = sel_cnt - CNT_W'(1);
  assign upd_src = (sel_step == STEP_SRC) ? sel_src + step_amt : sel_src;
  assign upd_dst = (sel_step == STEP_DST) ? sel_dst + step_amt : sel_dst;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      cur_ch    <= '0;
      byte_q    <= 1'b0;
      src_odd   <= 1'b0;
      mem_re    <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_be    <= '0;
      mem_wdata <= '0;
      done      <= '0;
      irq       <= '0;
    end else begin
      done <= '0;
      irq  <= '0;
      case (state)
        S_IDLE: begin
          if (any_pend) begin
            cur_ch <= win_ch;
            if (sel_cnt == '0) begin
              irq[win_ch] <= 1'b1;
            end else begin
              byte_q   <= sel_byte;
              src_odd  <= sel_src[0];
              mem_re   <= 1'b1;
              mem_addr <= bus_addr(sel_src, sel_byte);
              mem_be   <= lane_en(sel_src[0], sel_byte);
              state    <= S_RD;
            end
          end
        end
        S_RD: begin
          mem_re <= 1'b0;
          state  <= S_WAIT;
        end
        S_WAIT: begin
          mem_we    <= 1'b1;
          mem_addr  <= bus_addr(sel_dst, byte_q);
          mem_be    <= lane_en(sel_dst[0], byte_q);
          mem_wdata <= byte_q ? {rd_byte, rd_byte} : mem_rdata;
          state     <= S_WR;
        end
        S_WR: begin
          mem_we       <= 1'b0;
          mem_be       <= '0;
          done[cur_ch] <= 1'b1;
          state        <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/evx_dma.sv
module evx_dma #(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 8,
  parameter int PTR_W  = 16,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int RA_W  = CH_W + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] req_i,
  input  logic              reg_we_i,
  input  logic [RA_W-1:0]   reg_addr_i,
  input  logic [15:0]       reg_wdata_i,
  output logic [15:0]       reg_rdata_o,
  output logic              mem_re_o,
  output logic              mem_we_o,
  output logic [PTR_W-1:0]  mem_addr_o,
  output logic [1:0]        mem_be_o,
  output logic [15:0]       mem_wdata_o,
  input  logic [15:0]       mem_rdata_i,
  output logic [NUM_CH-1:0] done_o,
  output logic [NUM_CH-1:0] irq_o
);
  logic             any_pend, take, upd_en, sel_byte;
  logic [CH_W-1:0]  win_ch, sel_ch;
  logic [CNT_W-1:0] sel_cnt, upd_cnt;
  logic [1:0]       sel_step;
  logic [PTR_W-1:0] sel_src, sel_dst, upd_src, upd_dst;

  evx_regfile #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .PTR_W(PTR_W)) regs_i (
    .clk(clk), .rst(rst),
    .host_we(reg_we_i), .host_addr(reg_addr_i), .host_wdata(reg_wdata_i),
    .host_rdata(reg_rdata_o),
    .sel_ch(sel_ch), .sel_cnt(sel_cnt), .sel_byte(sel_byte), .sel_step(sel_step),
    .sel_src(sel_src), .sel_dst(sel_dst),
    .upd_en(upd_en), .upd_ch(sel_ch), .upd_cnt(upd_cnt),
    .upd_src(upd_src), .upd_dst(upd_dst)
  );

  evx_arbiter #(.NUM_CH(NUM_CH)) arb_i (
    .clk(clk), .rst(rst), .req_i(req_i),
    .take_i(take), .take_ch_i(win_ch),
    .any_o(any_pend), .win_o(win_ch)
  );

  evx_engine #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .PTR_W(PTR_W)) eng_i (
    .clk(clk), .rst(rst),
    .any_pend(any_pend), .win_ch(win_ch), .take(take), .sel_ch(sel_ch),
    .sel_cnt(sel_cnt), .sel_byte(sel_byte), .sel_step(sel_step),
    .sel_src(sel_src), .sel_dst(sel_dst),
    .upd_en(upd_en), .upd_cnt(upd_cnt), .upd_src(upd_src), .upd_dst(upd_dst),
    .mem_re(mem_re_o), .mem_we(mem_we_o), .mem_addr(mem_addr_o),
    .mem_be(mem_be_o), .mem_wdata(mem_wdata_o), .mem_rdata(mem_rdata_i),
    .done(done_o), .irq(irq_o)
  );
endmodule

// File: rtl/evx_dma_chk.sv
module evx_dma_chk #(
  parameter int NUM_CH = 8,
  parameter int PTR_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_re_o,
  input logic              mem_we_o,
  input logic [PTR_W-1:0]  mem_addr_o,
  input logic [1:0]        mem_be_o,
  input logic [NUM_CH-1:0] done_o,
  input logic [NUM_CH-1:0] irq_o
);
  a_r10_write_after_read: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> $past(mem_re_o, 2));
  a_r10_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(mem_re_o && mem_we_o));
  a_r3_word_even: assert property (@(posedge clk) disable iff (rst)
    ((mem_re_o || mem_we_o) && mem_be_o == 2'b11) |-> !mem_addr_o[0]);
  a_r4_byte_lane: assert property (@(posedge clk) disable iff (rst)
    ((mem_re_o || mem_we_o) && mem_be_o != 2'b11) |->
      (mem_be_o == (mem_addr_o[0] ? 2'b10 : 2'b01)));
  a_r9_done_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(done_o));
  a_r9_done_after_write: assert property (@(posedge clk) disable iff (rst)
    (|done_o) |-> $past(mem_we_o));
  a_r7_irq_quiet: assert property (@(posedge clk) disable iff (rst)
    (|irq_o) |-> (!mem_re_o && !mem_we_o && done_o == '0 && $onehot(irq_o)));
endmodule

bind evx_dma evx_dma_chk #(.NUM_CH(NUM_CH), .PTR_W(PTR_W)) chk_i (
  .clk(clk), .rst(rst), .mem_re_o(mem_re_o), .mem_we_o(mem_we_o),
  .mem_addr_o(mem_addr_o), .mem_be_o(mem_be_o), .done_o(done_o), .irq_o(irq_o)
);

// File: tb/evx_dma_tb_top.sv
`timescale 1ns/1ps
module evx_dma_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  req_i = '0;
  logic        reg_we_i = 1'b0;
  logic [5:0]  reg_addr_i = '0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic        mem_re_o, mem_we_o;
  logic [15:0] mem_addr_o, mem_wdata_o;
  logic [1:0]  mem_be_o;
  logic [15:0] mem_rdata_i = '0;
  logic [7:0]  done_o, irq_o;

  int n_chk = 0, n_err = 0;
  int cyc = 0, n_reads = 0, t_re = 0, t_we = 0;
  int log_ch [16];
  int n_log = 0;
  bit finished = 0;
  logic [15:0] mem [512];

  always #2.5 clk = ~clk;

  evx_dma dut_i (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_re_o) begin
      mem_rdata_i <= mem[mem_addr_o[9:1]];
      n_reads <= n_reads + 1;
      t_re <= cyc;
    end
    if (mem_we_o) begin
      t_we <= cyc;
      if (mem_be_o[0]) mem[mem_addr_o[9:1]][7:0]  <= mem_wdata_o[7:0];
      if (mem_be_o[1]) mem[mem_addr_o[9:1]][15:8] <= mem_wdata_o[15:8];
    end
    for (int i = 0; i < 8; i++)
      if (done_o[i] && n_log < 16) begin log_ch[n_log] = i; n_log++; end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr_i = a;
    @(negedge clk);
    d = reg_rdata_o;
  endtask

  function automatic logic [15:0] ctl(input int cnt, input bit b, input logic [1:0] s);
    return {5'b0, s, b, 8'(cnt)};
  endfunction

  function automatic logic [7:0] get_byte(input logic [15:0] a);
    return a[0] ? mem[a[9:1]][15:8] : mem[a[9:1]][7:0];
  endfunction

  task automatic pulse(input logic [7:0] r);
    @(negedge clk); req_i = r;
    @(negedge clk); req_i = '0;
  endtask

  task automatic wait_evt(output logic [7:0] dn, output logic [7:0] iq);
    dn = '0; iq = '0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (done_o != 0 || irq_o != 0) begin dn = done_o; iq = irq_o; break; end
    end
  endtask

  task automatic run_one(input string tag, input int ch, input bit b, input logic [1:0] s,
                         input int cnt, input logic [15:0] src, input logic [15:0] dst);
    logic [15:0] v, exp_w, old_dst, es, ed;
    logic [7:0] dn, iq, sb;
    int rd0;
    wr(6'(2*ch), ctl(cnt, b, s));
    wr(6'(16 + 2*ch), src);
    wr(6'(32 + 2*ch), dst);
    old_dst = mem[dst[9:1]];
    exp_w = mem[src[9:1]];
    sb = get_byte(src);
    rd0 = n_reads;
    pulse(8'(1) << ch);
    wait_evt(dn, iq);
    if (cnt == 0) begin
      chk({tag, " R7 irq"}, iq, 8'(1) << ch);
      chk({tag, " R7 no done"}, dn, 0);
      chk({tag, " R7 no read"}, n_reads - rd0, 0);
      chk({tag, " R7 dst untouched"}, mem[dst[9:1]], old_dst);
      es = src; ed = dst;
    end else begin
      chk({tag, " R9 done"}, dn, 8'(1) << ch);
      chk({tag, " R10 gap"}, t_we - t_re, 2);
      if (!b) chk({tag, " R3 word"}, mem[dst[9:1]], exp_w);
      else begin
        chk({tag, " R4 byte"}, get_byte(dst), sb);
        chk({tag, " R4 other lane"}, dst[0] ? mem[dst[9:1]][7:0] : mem[dst[9:1]][15:8],
            dst[0] ? old_dst[7:0] : old_dst[15:8]);
      end
      es = (s == 2'b10) ? src + (b ? 16'd1 : 16'd2) : src;
      ed = (s == 2'b01) ? dst + (b ? 16'd1 : 16'd2) : dst;
    end
    rd(6'(2*ch), v);
    chk({tag, " R6 count"}, v, ctl(cnt == 0 ? 0 : cnt - 1, b, s));
    rd(6'(16 + 2*ch), v); chk({tag, " R5 src"}, v, es);
    rd(6'(32 + 2*ch), v); chk({tag, " R5 dst"}, v, ed);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    if (!finished) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd4711));
    for (int i = 0; i < 512; i++) mem[i] = 16'($urandom);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    chk("R1 strobes", {mem_re_o, mem_we_o, done_o, irq_o}, 0);
    for (int a = 0; a < 48; a += 2) begin
      rd(6'(a), v); chk("R1 reset regs", v, 0);
    end
    wr(6'h06, 16'hFFFF); rd(6'h06, v); chk("R2 step 11 coerced", v, 16'h05FF);
    wr(6'h07, 16'h02AB); rd(6'h06, v); chk("R11 bit0 ignored", v, 16'h02AB);
    wr(6'h31, 16'h1234); rd(6'h31, v); chk("R11 unmapped", v, 0);
    wr(6'h1A, 16'hBEEF); rd(6'h1A, v); chk("R11 src slot", v, 16'hBEEF);
    // directed corners
    run_one("word odd addrs", 1, 1'b0, 2'b10, 3, 16'h0011, 16'h0101);
    run_one("byte odd->even", 2, 1'b1, 2'b01, 1, 16'h0023, 16'h0140);
    run_one("byte even->odd", 3, 1'b1, 2'b00, 200, 16'h0030, 16'h0161);
    run_one("zero count", 4, 1'b0, 2'b01, 0, 16'h0040, 16'h0180);
    // priority
    wr(6'h00, ctl(5, 0, 0)); wr(6'h10, 16'h0200); wr(6'h20, 16'h0300);
    wr(6'h04, ctl(5, 0, 0)); wr(6'h14, 16'h0202); wr(6'h24, 16'h0302);
    wr(6'h0E, ctl(5, 1, 0)); wr(6'h1E, 16'h0204); wr(6'h2E, 16'h0304);
    n_log = 0;
    pulse(8'h84);
    @(negedge clk); req_i = 8'h01; @(negedge clk); req_i = '0;
    repeat (30) @(negedge clk);
    chk("R8 count", n_log, 3);
    chk("R8 first", log_ch[0], 2);
    chk("R8 second", log_ch[1], 0);
    chk("R8 third", log_ch[2], 7);
    // random
    for (int it = 0; it < 60; it++) begin
      int ch, cnt;
      bit b;
      logic [1:0] s;
      ch = $urandom % 8; b = 1'($urandom); s = 2'($urandom % 3);
      cnt = ($urandom % 6 == 0) ? 0 : 1 + $urandom % 255;
      run_one("rand", ch, b, s, cnt, 16'($urandom % 1000), 16'($urandom % 1000));
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule